// File: doc/BRIEF.md
# Memory Power-Up Initialization Sequencer

This block is the controller-side state machine that takes a fast-cycle DDR network memory from power-on to normal operation. After reset it keeps the memory's power-down pin low and drives deselect on the command bus. It waits for a power-good indication, then counts out a stable-clock interval whose length is a parameter computed from the clock period. When that interval ends, it sends one more deselect and then releases power-down.

Next it programs the extended mode register (DLL on, driver strength, strobe style) and then the standard mode register (CAS latency, burst type, burst length). It then issues a parameterized number of auto-refresh operations. Every mode-register write goes out as a two-command pair: a read-with-autoclose command followed by the mode-set command, which carries the op-code on the address bus. Every refresh goes out as a write-with-autoclose command followed by the refresh command. Idle cycles between pairs carry deselect, and each gap has a minimum length set by a parameter.

The ready flag is timed from the extended-mode programming cycle, so the DLL lock interval is always honoured. Alongside ready, the block exports the derived write latency. A configuration outside the legal CAS latency or burst length sets halts the sequence before any mode command is issued, and raises an error flag.

Top module: `mem_init_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `pd_n_o`=0, `cmd_o`=deselect, `addr_o`=0, `ready_o`=0, `cfg_err_o`=0 and `wr_lat_o`=0.
- R2: Once `pwr_good_i` is seen high, `pd_n_o` stays low for `STABLE_CYC` cycles plus one further deselect cycle, and then goes high. If `pwr_good_i` drops before that deselect cycle, the count restarts from zero when it returns.
- R3: Command encoding on `cmd_o`: deselect=0, read-with-autoclose=1, write-with-autoclose=2, mode-set=3, refresh=4. Every cycle that carries no command shows deselect. No command other than deselect appears while `pd_n_o` is low.
- R4: After `pd_n_o` rises, `MRD_GAP` deselect cycles follow. Then the extended-mode pair is sent: read-with-autoclose, then mode-set with `addr_o[ADDR_W-1]`=1, bit0=1 (DLL on), bit1=driver strength, bit2=strobe style, and all other bits 0.
- R5: The next pair is the standard mode pair: read-with-autoclose, then mode-set with `addr_o[ADDR_W-1]`=0, bits[2:0]=burst length code (2 gives 3'b001, 4 gives 3'b010), bit3=burst type, bits[6:4]=CAS latency value, and all other bits 0.
- R6: After the two mode pairs, `REF_N` refresh pairs follow, each a write-with-autoclose then a refresh, with `addr_o`=0.
- R7: Exactly `MRD_GAP` deselect cycles follow each mode-set command, and exactly `RFC_GAP` follow each refresh command.
- R8: `ready_o` rises exactly `LOCK_CYC` cycles after the extended mode-set cycle when the refreshes are done by then, never earlier, and stays high until reset.
- R9: `wr_lat_o` equals the programmed CAS latency minus one while `ready_o` is high, and 0 otherwise.
- R10: A CAS latency outside {4,5,6} or a burst length outside {2,4} raises `cfg_err_o` in the cycle after the final deselect of the wait. After that, `pd_n_o` stays low, only deselect is issued and `ready_o` never rises.
- R11: The configuration inputs are captured in the final deselect cycle of the wait. Changes after that have no effect on the op-codes or on `wr_lat_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good_i | input | 1 | Supplies and clock are up |
| cfg_cas_i | input | 3 | CAS latency value |
| cfg_blen_i | input | 3 | Burst length value |
| cfg_btype_i | input | 1 | Burst type |
| cfg_drv_i | input | 1 | Output driver strength select |
| cfg_strobe_i | input | 1 | Data strobe style select |
| cmd_o | output | 3 | Memory command |
| addr_o | output | ADDR_W | Address / op-code bus |
| pd_n_o | output | 1 | Power-down pin, low = powered down |
| ready_o | output | 1 | Initialization complete |
| wr_lat_o | output | 3 | Derived write latency |
| cfg_err_o | output | 1 | Illegal configuration, sequence halted |

## Verification
The bench measures the exact length of the power-down hold. A sequencer that is off by one there, or that releases power-down in the same cycle as the last deselect, gives the wrong count. It also drops power-good partway through the wait: a design that keeps its count instead of restarting releases power-down too early. Each legal configuration is checked for pair order, op-code bit placement and gap lengths, which catches swapped mode pairs, mis-placed fields and short gaps. Ready is timed against the extended mode-set cycle, so timing it from the last command shows up as a shifted rise. Illegal CAS latency and burst length values must produce no command at all, and configuration changes made after capture must leave the op-codes and the write latency untouched.

// File: rtl/mem_init_pkg.sv
package mem_init_pkg;

  typedef enum logic [2:0] {
    CMD_DESL = 3'd0,
    CMD_RDA  = 3'd1,
    CMD_WRA  = 3'd2,
    CMD_MRS  = 3'd3,
    CMD_REF  = 3'd4
  } mem_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_STABLE,
    ST_DESL,
    ST_UP,
    ST_PRE,
    ST_CMD,
    ST_GAP,
    ST_LOCK,
    ST_READY,
    ST_ERR
  } seq_st_e;

  function automatic logic cfg_legal(input logic [2:0] cas, input logic [2:0] blen);
    return (cas >= 3'd4) && (cas <= 3'd6) && ((blen == 3'd2) || (blen == 3'd4));
  endfunction

endpackage

// File: rtl/cyc_counter.sv
module cyc_counter #(
  parameter int unsigned MAX = 255,
  parameter int unsigned W   = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAX_V = W'(MAX);

  always_ff @(posedge clk) begin
    if (rst || clr)                cnt <= '0;
    else if (inc && (cnt < MAX_V)) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mode_word_gen.sv
module mode_word_gen #(
  parameter int unsigned ADDR_W = 15
) (
  input  logic [2:0]        cas,
  input  logic [2:0]        blen,
  input  logic              btype,
  input  logic              drv,
  input  logic              strobe,
  output logic [ADDR_W-1:0] ext_word,
  output logic [ADDR_W-1:0] std_word,
  output logic [2:0]        wr_lat
);
  always_comb begin
    ext_word             = '0;
    ext_word[ADDR_W-1]   = 1'b1;
    ext_word[0]          = 1'b1;
    ext_word[1]          = drv;
    ext_word[2]          = strobe;

    std_word             = '0;
    std_word[2:0]        = (blen == 3'd4) ? 3'b010 : 3'b001;
    std_word[3]          = btype;
    std_word[6:4]        = cas;

    wr_lat               = cas - 3'd1;
  end
endmodule

// File: rtl/mem_init_seq.sv
module mem_init_seq
  import mem_init_pkg::*;
#(
  parameter int unsigned CLK_PS     = 3000,
  parameter int unsigned STABLE_NS  = 200000,
  parameter int unsigned STABLE_CYC = (STABLE_NS * 1000 + CLK_PS - 1) / CLK_PS,
  parameter int unsigned LOCK_CYC   = 200,
  parameter int unsigned MRD_GAP    = 2,
  parameter int unsigned RFC_GAP    = 7,
  parameter int unsigned REF_N      = 2,
  parameter int unsigned ADDR_W     = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_good_i,
  input  logic [2:0]        cfg_cas_i,
  input  logic [2:0]        cfg_blen_i,
  input  logic              cfg_btype_i,
  input  logic              cfg_drv_i,
  input  logic              cfg_strobe_i,
  output logic [2:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              pd_n_o,
  output logic              ready_o,
  output logic [2:0]        wr_lat_o,
  output logic              cfg_err_o
);
  localparam int unsigned WAIT_MAX = (STABLE_CYC > MRD_GAP) ?
                                     ((STABLE_CYC > RFC_GAP) ? STABLE_CYC : RFC_GAP) :
                                     ((MRD_GAP > RFC_GAP) ? MRD_GAP : RFC_GAP);
  localparam int unsigned WAIT_W = $clog2(WAIT_MAX + 1);
  localparam int unsigned LOCK_W = $clog2(LOCK_CYC + 1);
  localparam int unsigned STEP_N = 2 + REF_N;
  localparam int unsigned STEP_W = $clog2(STEP_N);

  localparam logic [WAIT_W-1:0] STB_LAST = WAIT_W'(STABLE_CYC - 1);
  localparam logic [WAIT_W-1:0] MRD_LAST = WAIT_W'(MRD_GAP - 1);
  localparam logic [WAIT_W-1:0] RFC_LAST = WAIT_W'(RFC_GAP - 1);
  localparam logic [LOCK_W-1:0] LCK_LAST = LOCK_W'(LOCK_CYC - 1);
  localparam logic [STEP_W-1:0] STEP_REF = STEP_W'(2);
  localparam logic [STEP_W-1:0] STEP_END = STEP_W'(STEP_N - 1);

  if (ADDR_W < 8) begin : g_addr_chk
    $error("ADDR_W must be at least 8");
  end
  if ((MRD_GAP < 1) || (RFC_GAP < 1) || (STABLE_CYC < 1) || (LOCK_CYC < 1) || (REF_N < 2)) begin : g_par_chk
    $error("gaps, waits must be nonzero and REF_N at least 2");
  end

  seq_st_e             state_q, state_d;
  logic [STEP_W-1:0]   step_q, step_d;
  logic [WAIT_W-1:0]   wait_cnt;
  logic [LOCK_W-1:0]   lock_cnt;

  logic [2:0]          cas_q, blen_q;
  logic                btype_q, drv_q, strobe_q;
  logic [ADDR_W-1:0]   ext_word, std_word;
  logic [2:0]          wl;

  logic [2:0]          cmd_d;
  logic [ADDR_W-1:0]   addr_d;

  // Wait counter: restarts on every state change
  cyc_counter #(.MAX(WAIT_MAX), .W(WAIT_W)) wait_ctr_i (
    .clk (clk),
    .rst (rst),
    .clr (state_d != state_q),
    .inc (1'b1),
    .cnt (wait_cnt)
  );

  // DLL lock counter: starts in the extended mode-set cycle
  cyc_counter #(.MAX(LOCK_CYC), .W(LOCK_W)) lock_ctr_i (
    .clk (clk),
    .rst (rst),
    .clr (state_q == ST_IDLE),
    .inc (((state_q == ST_CMD) && (step_q == '0)) || (lock_cnt != '0)),
    .cnt (lock_cnt)
  );

  mode_word_gen #(.ADDR_W(ADDR_W)) words_i (
    .cas      (cas_q),
    .blen     (blen_q),
    .btype    (btype_q),
    .drv      (drv_q),
    .strobe   (strobe_q),
    .ext_word (ext_word),
    .std_word (std_word),
    .wr_lat   (wl)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    unique case (state_q)
      ST_IDLE:   if (pwr_good_i) state_d = ST_STABLE;
      ST_STABLE: begin
        if (!pwr_good_i)                state_d = ST_IDLE;
        else if (wait_cnt == STB_LAST)  state_d = ST_DESL;
      end
      ST_DESL:   state_d = cfg_legal(cfg_cas_i, cfg_blen_i) ? ST_UP : ST_ERR;
      ST_UP: begin
        if (wait_cnt == MRD_LAST) begin
          state_d = ST_PRE;
          step_d  = '0;
        end
      end
      ST_PRE:    state_d = ST_CMD;
      ST_CMD:    state_d = ST_GAP;
      ST_GAP: begin
        if (wait_cnt == ((step_q < STEP_REF) ? MRD_LAST : RFC_LAST)) begin
          if (step_q == STEP_END) state_d = ST_LOCK;
          else begin
            state_d = ST_PRE;
            step_d  = step_q + 1'b1;
          end
        end
      end
      ST_LOCK:   if (lock_cnt >= LCK_LAST) state_d = ST_READY;
      ST_READY:  state_d = ST_READY;
      ST_ERR:    state_d = ST_ERR;
      default:   state_d = ST_IDLE;
    endcase
  end

  // Output decode from the next state, registered below
  always_comb begin
    cmd_d  = CMD_DESL;
    addr_d = '0;
    if (state_d == ST_PRE) begin
      cmd_d = (step_d < STEP_REF) ? CMD_RDA : CMD_WRA;
    end else if (state_d == ST_CMD) begin
      cmd_d = (step_d < STEP_REF) ? CMD_MRS : CMD_REF;
      if (step_d == '0)                 addr_d = ext_word;
      else if (step_d == STEP_W'(1))    addr_d = std_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      step_q    <= '0;
      cas_q     <= '0;
      blen_q    <= '0;
      btype_q   <= 1'b0;
      drv_q     <= 1'b0;
      strobe_q  <= 1'b0;
      cmd_o     <= CMD_DESL;
      addr_o    <= '0;
      pd_n_o    <= 1'b0;
      ready_o   <= 1'b0;
      wr_lat_o  <= '0;
      cfg_err_o <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      if (state_q == ST_DESL) begin
        cas_q    <= cfg_cas_i;
        blen_q   <= cfg_blen_i;
        btype_q  <= cfg_btype_i;
        drv_q    <= cfg_drv_i;
        strobe_q <= cfg_strobe_i;
      end
      cmd_o     <= cmd_d;
      addr_o    <= addr_d;
      pd_n_o    <= !((state_d == ST_IDLE) || (state_d == ST_STABLE) ||
                     (state_d == ST_DESL) || (state_d == ST_ERR));
      ready_o   <= (state_d == ST_READY);
      wr_lat_o  <= (state_d == ST_READY) ? wl : 3'd0;
      cfg_err_o <= (state_d == ST_ERR);
    end
  end
endmodule

// File: rtl/mem_init_seq_chk.sv
module mem_init_seq_chk
  import mem_init_pkg::*;
#(
  parameter int unsigned LOCK_CYC = 200,
  parameter int unsigned ADDR_W   = 15
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        cmd_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              pd_n_o,
  input logic              ready_o,
  input logic [2:0]        wr_lat_o,
  input logic              cfg_err_o
);
  localparam int unsigned LW = $clog2(LOCK_CYC + 1);
  localparam logic [LW-1:0] LOCK_V = LW'(LOCK_CYC);

  logic [LW-1:0] since_ext;
  always_ff @(posedge clk) begin
    if (rst) since_ext <= '0;
    else if ((cmd_o == CMD_MRS) && addr_o[ADDR_W-1]) since_ext <= LW'(1);
    else if ((since_ext != '0) && (since_ext < LOCK_V)) since_ext <= since_ext + 1'b1;
  end

  p_pd_rise_after_desl_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_n_o) |-> ($past(cmd_o) == CMD_DESL));

  p_no_cmd_pd_low_r3: assert property (@(posedge clk) disable iff (rst)
    !pd_n_o |-> (cmd_o == CMD_DESL));

  p_rda_then_mrs_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_RDA) |=> (cmd_o == CMD_MRS));

  p_mrs_after_rda_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_MRS) |-> ($past(cmd_o) == CMD_RDA));

  p_wra_then_ref_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_WRA) |=> (cmd_o == CMD_REF));

  p_desl_after_cmd_r7: assert property (@(posedge clk) disable iff (rst)
    ((cmd_o == CMD_MRS) || (cmd_o == CMD_REF)) |=> (cmd_o == CMD_DESL));

  p_ready_lock_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> (since_ext == LOCK_V));

  p_ready_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> ready_o);

  p_wrlat_range_r9: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> ((wr_lat_o >= 3'd3) && (wr_lat_o <= 3'd5)));

  p_wrlat_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !ready_o |-> (wr_lat_o == 3'd0));

  p_err_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    cfg_err_o |-> ((cmd_o == CMD_DESL) && !pd_n_o && !ready_o));
endmodule

bind mem_init_seq mem_init_seq_chk #(.LOCK_CYC(LOCK_CYC), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cmd_o     (cmd_o),
  .addr_o    (addr_o),
  .pd_n_o    (pd_n_o),
  .ready_o   (ready_o),
  .wr_lat_o  (wr_lat_o),
  .cfg_err_o (cfg_err_o)
);

// File: tb/mem_init_seq_tb_top.sv
module mem_init_seq_tb_top;
  localparam int STB = 20;
  localparam int LCK = 60;
  localparam int MG  = 2;
  localparam int RG  = 5;
  localparam int RN  = 2;
  localparam int AW  = 15;
  localparam int NEV = 4 + 2 * RN;

  // fields: [9:7] CAS, [6:4] burst length, [3] burst type, [2] driver, [1] strobe, [0] legal
  localparam logic [9:0] VEC [0:6] = '{
    10'b100_010_0_0_0_1,
    10'b101_100_1_1_0_1,
    10'b110_100_0_0_1_1,
    10'b110_010_1_1_1_1,
    10'b011_100_0_0_0_0,
    10'b101_011_0_0_0_0,
    10'b111_010_0_0_0_0
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pwr_good = 1'b0;
  logic [2:0]    cas = 3'd4, blen = 3'd2;
  logic          btype = 1'b0, drv = 1'b0, strobe = 1'b0;
  logic [2:0]    cmd;
  logic [AW-1:0] addr;
  logic          pd_n, ready, cfg_err;
  logic [2:0]    wr_lat;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  mem_init_seq #(
    .STABLE_CYC(STB), .LOCK_CYC(LCK), .MRD_GAP(MG), .RFC_GAP(RG),
    .REF_N(RN), .ADDR_W(AW)
  ) dut_i (
    .clk(clk), .rst(rst), .pwr_good_i(pwr_good),
    .cfg_cas_i(cas), .cfg_blen_i(blen), .cfg_btype_i(btype),
    .cfg_drv_i(drv), .cfg_strobe_i(strobe),
    .cmd_o(cmd), .addr_o(addr), .pd_n_o(pd_n), .ready_o(ready),
    .wr_lat_o(wr_lat), .cfg_err_o(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    pwr_good = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_case(input logic [9:0] v, input bit mutate);
    logic [2:0] c = v[9:7];
    logic [2:0] b = v[6:4];
    bit legal = v[0];
    logic [AW-1:0] exp_ext, exp_std;
    int ev_t [NEV];
    logic [2:0] ev_c [NEV];
    logic [AW-1:0] ev_a [NEV];
    int n_ev = 0, low_cnt = 0, t_rise = -1, t_emrs = -1, t_ready = -1, t_err = -1;
    int bad_low = 0, wl_bad = 0, extra = 0, wl_at_ready = -1, late_drop = 0;
    do_reset();
    cas = c; blen = b; btype = v[3]; drv = v[2]; strobe = v[1];
    exp_ext = '0; exp_ext[AW-1] = 1'b1; exp_ext[0] = 1'b1; exp_ext[1] = v[2]; exp_ext[2] = v[1];
    exp_std = '0; exp_std[2:0] = (b == 3'd4) ? 3'b010 : 3'b001; exp_std[3] = v[3]; exp_std[6:4] = c;
    pwr_good = 1'b1;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (!pd_n && t_rise < 0) low_cnt++;
      if (pd_n && t_rise < 0) begin
        t_rise = k;
        if (mutate) begin
          cas = (c == 3'd4) ? 3'd5 : 3'd4; btype = ~btype; drv = ~drv; strobe = ~strobe;
          blen = (b == 3'd2) ? 3'd4 : 3'd2;
        end
      end
      if (!pd_n && cmd != 3'd0) bad_low++;
      if (cmd != 3'd0) begin
        if (n_ev < NEV) begin ev_t[n_ev] = k; ev_c[n_ev] = cmd; ev_a[n_ev] = addr; end
        n_ev++;
        if (cmd == 3'd3 && addr[AW-1] && t_emrs < 0) t_emrs = k;
      end
      if (!ready && wr_lat != 3'd0) wl_bad++;
      if (cfg_err && t_err < 0) t_err = k;
      if (t_ready >= 0 && !ready) late_drop++;
      if (ready && t_ready < 0) begin t_ready = k; wl_at_ready = wr_lat; end
      if (t_ready >= 0) begin extra++; if (extra > 5) break; end
    end
    chk(bad_low == 0, "R3", "commands while power-down low", bad_low, 0);
    chk(wl_bad == 0, "R9", "write latency nonzero before ready", wl_bad, 0);
    if (legal) begin
      chk(low_cnt == STB + 1, "R2", "power-down low cycles", low_cnt, STB + 1);
      chk(n_ev == NEV, "R3", "number of command cycles", n_ev, NEV);
      if (n_ev == NEV) begin
        chk(ev_t[0] == t_rise + MG, "R4", "first command cycle", ev_t[0], t_rise + MG);
        chk(ev_c[0] == 3'd1 && ev_c[1] == 3'd3, "R4", "extended pair cmds", {ev_c[0], ev_c[1]}, {3'd1, 3'd3});
        chk(ev_a[1] == exp_ext, "R4", "extended op-code", ev_a[1], exp_ext);
        chk(ev_t[1] == ev_t[0] + 1, "R4", "pair adjacency", ev_t[1], ev_t[0] + 1);
        chk(ev_c[2] == 3'd1 && ev_c[3] == 3'd3, "R5", "standard pair cmds", {ev_c[2], ev_c[3]}, {3'd1, 3'd3});
        chk(ev_a[3] == exp_std, "R5", mutate ? "op-code after late change (R11)" : "standard op-code", ev_a[3], exp_std);
        for (int r = 0; r < RN; r++) begin
          chk(ev_c[4+2*r] == 3'd2 && ev_c[5+2*r] == 3'd4, "R6", "refresh pair cmds",
              {ev_c[4+2*r], ev_c[5+2*r]}, {3'd2, 3'd4});
          chk(ev_a[5+2*r] == '0, "R6", "refresh address", ev_a[5+2*r], 0);
          chk(ev_t[5+2*r] == ev_t[4+2*r] + 1, "R6", "refresh pair adjacency", ev_t[5+2*r], ev_t[4+2*r] + 1);
        end
        chk(ev_t[2] - ev_t[1] == MG + 1, "R7", "gap after extended set", ev_t[2] - ev_t[1], MG + 1);
        chk(ev_t[4] - ev_t[3] == MG + 1, "R7", "gap after standard set", ev_t[4] - ev_t[3], MG + 1);
        chk(ev_t[6] - ev_t[5] == RG + 1, "R7", "gap after refresh", ev_t[6] - ev_t[5], RG + 1);
      end
      chk(t_ready - t_emrs == LCK, "R8", "ready delay from extended set", t_ready - t_emrs, LCK);
      chk(late_drop == 0 && extra > 5, "R8", "ready held", late_drop, 0);
      chk(wl_at_ready == c - 1, mutate ? "R11" : "R9", "write latency", wl_at_ready, c - 1);
      chk(t_err < 0, "R10", "no error on legal config", t_err, -1);
    end else begin
      chk(t_err == STB + 1, "R10", "error flag cycle", t_err, STB + 1);
      chk(n_ev == 0, "R10", "commands on illegal config", n_ev, 0);
      chk(t_rise < 0, "R10", "power-down released", t_rise, -1);
      chk(t_ready < 0, "R10", "ready on illegal config", t_ready, -1);
    end
    pwr_good = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state, during and right after reset
    repeat (2) @(negedge clk);
    chk(pd_n == 0 && cmd == 3'd0 && addr == '0 && !ready && !cfg_err && wr_lat == 0,
        "R1", "outputs in reset", {pd_n, cmd, ready, cfg_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(pd_n == 0 && cmd == 3'd0 && !ready && !cfg_err, "R1", "outputs after reset",
        {pd_n, cmd, ready, cfg_err}, 0);
    // R2: stays powered down while power-good is low
    repeat (30) @(negedge clk);
    chk(pd_n == 0 && cmd == 3'd0, "R2", "waiting without power-good", pd_n, 0);

    // table walk: legal and illegal configurations
    for (int i = 0; i < 7; i++) run_case(VEC[i], 1'b0);

    // R11: configuration changed after capture
    run_case(VEC[1], 1'b1);

    // R2: power-good glitch restarts the wait
    begin
      int lows = 0;
      do_reset();
      cas = 3'd5; blen = 3'd4; btype = 0; drv = 0; strobe = 0;
      pwr_good = 1'b1;
      repeat (12) @(negedge clk);
      pwr_good = 1'b0;
      repeat (2) @(negedge clk);
      chk(pd_n == 0, "R2", "power-down during glitch", pd_n, 0);
      pwr_good = 1'b1;
      for (int k = 0; k < 100; k++) begin
        @(negedge clk);
        if (pd_n) break;
        lows++;
      end
      chk(lows == STB + 1, "R2", "low cycles after restart", lows, STB + 1);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule